// File: doc/BRIEF.md
# Link Receive Control-Word Demultiplexer

This block sits behind a serial link receiver that has already decoded the line into 32-bit words. Each decoded word is flagged as either a data word or a control word. Data words are written into a receive FIFO, from which a host read port takes them one at a time. Control words are never stored. Their sideband flags are split two ways. The frame-sync flag is held as pending and is attached, as a 33rd FIFO bit, to the next data word that is stored, so it stays aligned with the data stream. The not-ready, direction and two general-purpose flags are latched at once into a status output and have no alignment with the data.

The block also derives a suspend indication from the FIFO fill level, for the local transmitter to send back to the far end. Suspend uses hysteresis: it turns on at a programmable high mark and turns off only below a lower mark. A data word that arrives while the FIFO is full is discarded and sets a sticky overflow flag, which the host clears with a pulse. Receive must be enabled and loopback off for any incoming word to have an effect.

Top module: `link_rx_demux`

## Requirements
- R1: After reset, empty is 1, level is 0, suspend is 0, overflow is 0 and side_status is 0.
- R2: A data word (in_valid=1, in_is_ctrl=0) accepted while rx_enable=1 and loopback=0 is stored in the FIFO, and level counts it from the next cycle. rd_data/rd_sync always show the oldest stored entry, and an rd_en pulse removes it, so words come out in arrival order.
- R3: For a control word, in_word bits [4:0] are {pio2, pio1, sync, dir, nrdy}. From the next cycle, side_status = {pio2, pio1, dir, nrdy} (bit 3 down to bit 0). A control word never enters the FIFO.
- R4: A control word with sync=1 marks the next stored data word with rd_sync=1. Data words stored after that one have rd_sync=0 until another sync control word arrives.
- R5: A data word that arrives while level equals DEPTH is discarded. Overflow is set from the next cycle, and the FIFO contents and level are unchanged.
- R6: Overflow stays set until a cycle with ovf_clr=1 and no new discard. It reads 0 from the next cycle.
- R7: When level is at least hi_mark, suspend is 1 from the following cycle.
- R8: When level is below lo_mark, suspend is 0 from the following cycle. While level is from lo_mark up to but not including hi_mark, suspend keeps its value.
- R9: While rx_enable=0 or loopback=1, incoming words of either kind change neither the FIFO nor side_status.
- R10: rd_en while the FIFO is empty has no effect: level stays 0 and the next stored word reads out correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receive enable |
| loopback | input | 1 | Loopback mode; incoming words are ignored when set |
| in_valid | input | 1 | Decoded word present this cycle |
| in_is_ctrl | input | 1 | 1 for a control word, 0 for a data word |
| in_word | input | 32 | Decoded word |
| hi_mark | input | CNT_W | Fill level that turns suspend on |
| lo_mark | input | CNT_W | Fill level below which suspend turns off |
| rd_en | input | 1 | Remove the oldest entry |
| ovf_clr | input | 1 | Clear the overflow flag |
| rd_data | output | 32 | Oldest stored data word |
| rd_sync | output | 1 | Sync mark of the oldest stored word |
| empty | output | 1 | FIFO holds no entry |
| level | output | CNT_W | Number of stored entries |
| suspend | output | 1 | Back-pressure indication for the far end |
| overflow | output | 1 | Sticky flag: a data word was discarded |
| side_status | output | 4 | Latched {pio2, pio1, dir, nrdy} |

## Verification
A corrupted fill count shows at the level port in the cycle after the push or pop that caused it. One cycle later it also shows as suspend switching at the wrong level. A wrong read or write pointer shows only when that entry reaches the head, so the bench drains every word it stores and compares each one. A stale or lost pending-sync flag is invisible until its data word is read, so sync cases are always followed by a drain of at least two words.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int SIDE_W = 4;

  typedef struct packed {
    logic pio2;
    logic pio1;
    logic sync;
    logic dir;
    logic nrdy;
  } ctrl_bits_t;

  function automatic ctrl_bits_t ctrl_decode(input logic [31:0] w);
    return ctrl_bits_t'(w[4:0]);
  endfunction

  function automatic logic [SIDE_W-1:0] side_of(input ctrl_bits_t c);
    return {c.pio2, c.pio1, c.dir, c.nrdy};
  endfunction

  function automatic logic susp_next(input logic cur, input int unsigned lvl,
                                     input int unsigned hi, input int unsigned lo);
    if (lvl >= hi) return 1'b1;
    if (lvl < lo)  return 1'b0;
    return cur;
  endfunction

  function automatic int unsigned fill_next(input int unsigned cnt,
                                            input logic push, input logic pop);
    case ({push, pop})
      2'b10:   return cnt + 1;
      2'b01:   return cnt - 1;
      default: return cnt;
    endcase
  endfunction

endpackage

// File: rtl/rxd_classify.sv
module rxd_classify
  import rxd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              loopback,
  input  logic              in_valid,
  input  logic              in_is_ctrl,
  input  logic [DW-1:0]     in_word,
  input  logic              fifo_full,
  output logic              push,
  output logic              drop,
  output logic              ctrl_evt,
  output logic [DW:0]       wr_entry,
  output logic [SIDE_W-1:0] side_q
);

  logic       accept;
  logic       pend_q;
  ctrl_bits_t cb;

  assign accept   = in_valid && rx_enable && !loopback;
  assign ctrl_evt = accept && in_is_ctrl;
  assign push     = accept && !in_is_ctrl && !fifo_full;
  assign drop     = accept && !in_is_ctrl && fifo_full;
  assign cb       = ctrl_decode(in_word);
  assign wr_entry = {pend_q, in_word};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      side_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (ctrl_evt) begin
        side_q <= side_of(cb);
        if (cb.sync) pend_q <= 1'b1;
      end else if (push) begin
        pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rxd_fifo.sv
module rxd_fifo
  import rxd_pkg::*;
#(
  parameter int EW    = 33,
  parameter int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [EW-1:0]    wdata,
  output logic [EW-1:0]    rdata,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] level
);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop_ok;

  assign empty  = (level == '0);
  assign full   = (32'(level) == DEPTH);
  assign pop_ok = pop && !empty;
  assign rdata  = mem[rd_ptr];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    if (32'(p) == DEPTH - 1) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push)   wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok) rd_ptr <= ptr_inc(rd_ptr);
      level <= CNT_W'(fill_next(32'(level), push, pop_ok));
    end
  end

endmodule

// File: rtl/rxd_watermark.sv
module rxd_watermark
  import rxd_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] hi_mark,
  input  logic [CNT_W-1:0] lo_mark,
  output logic             suspend
);

  always_ff @(posedge clk) begin
    if (!rst_n) suspend <= 1'b0;
    else        suspend <= susp_next(suspend, 32'(level), 32'(hi_mark), 32'(lo_mark));
  end

endmodule

// File: rtl/link_rx_demux.sv
module link_rx_demux
  import rxd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              loopback,
  input  logic              in_valid,
  input  logic              in_is_ctrl,
  input  logic [DW-1:0]     in_word,
  input  logic [CNT_W-1:0]  hi_mark,
  input  logic [CNT_W-1:0]  lo_mark,
  input  logic              rd_en,
  input  logic              ovf_clr,
  output logic [DW-1:0]     rd_data,
  output logic              rd_sync,
  output logic              empty,
  output logic [CNT_W-1:0]  level,
  output logic              suspend,
  output logic              overflow,
  output logic [SIDE_W-1:0] side_status
);

  logic          push_evt, drop_evt, ctrl_evt, full_w;
  logic [DW:0]   wr_entry, rd_entry;

  rxd_classify #(.DW(DW)) u_cls (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .loopback(loopback),
    .in_valid(in_valid), .in_is_ctrl(in_is_ctrl), .in_word(in_word),
    .fifo_full(full_w), .push(push_evt), .drop(drop_evt), .ctrl_evt(ctrl_evt),
    .wr_entry(wr_entry), .side_q(side_status)
  );

  rxd_fifo #(.EW(DW + 1), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_evt), .pop(rd_en), .wdata(wr_entry),
    .rdata(rd_entry), .empty(empty), .full(full_w), .level(level)
  );

  rxd_watermark #(.CNT_W(CNT_W)) u_wm (
    .clk(clk), .rst_n(rst_n), .level(level), .hi_mark(hi_mark),
    .lo_mark(lo_mark), .suspend(suspend)
  );

  assign rd_data = rd_entry[DW-1:0];
  assign rd_sync = rd_entry[DW];

  always_ff @(posedge clk) begin
    if (!rst_n)        overflow <= 1'b0;
    else if (drop_evt) overflow <= 1'b1;
    else if (ovf_clr)  overflow <= 1'b0;
  end

endmodule

// File: rtl/rxd_checker.sv
module rxd_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_enable,
  input logic             loopback,
  input logic             in_valid,
  input logic [31:0]      in_word,
  input logic [CNT_W-1:0] hi_mark,
  input logic [CNT_W-1:0] lo_mark,
  input logic             rd_en,
  input logic             ovf_clr,
  input logic             empty,
  input logic [CNT_W-1:0] level,
  input logic             suspend,
  input logic             overflow,
  input logic [3:0]       side_status,
  input logic             push_evt,
  input logic             drop_evt,
  input logic             ctrl_evt
);

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);

  assert_drop_sets_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overflow);

  assert_drop_keeps_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && !rd_en) |=> $stable(level));

  assert_ovf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !drop_evt) |=> !overflow);

  assert_ctrl_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_evt |=> side_status == {$past(in_word[4]), $past(in_word[3]),
                                 $past(in_word[1]), $past(in_word[0])});

  assert_susp_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspend) |-> $past(level) >= $past(hi_mark));

  assert_susp_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(suspend) |-> $past(level) < $past(lo_mark));

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!rx_enable || loopback)) |-> (!push_evt && !ctrl_evt && !drop_evt));

  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !push_evt) |=> empty);

endmodule

bind link_rx_demux rxd_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .loopback(loopback),
  .in_valid(in_valid), .in_word(in_word), .hi_mark(hi_mark), .lo_mark(lo_mark),
  .rd_en(rd_en), .ovf_clr(ovf_clr), .empty(empty), .level(level),
  .suspend(suspend), .overflow(overflow), .side_status(side_status),
  .push_evt(push_evt), .drop_evt(drop_evt), .ctrl_evt(ctrl_evt)
);

// File: tb/sim_link_rx_demux.sv
module sim_link_rx_demux;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_enable = 1'b1, loopback = 1'b0;
  logic in_valid = 1'b0, in_is_ctrl = 1'b0;
  logic [31:0] in_word = '0;
  logic [CNT_W-1:0] hi_mark = CNT_W'(12), lo_mark = CNT_W'(4);
  logic rd_en = 1'b0, ovf_clr = 1'b0;
  logic [31:0] rd_data;
  logic rd_sync, empty, suspend, overflow;
  logic [CNT_W-1:0] level;
  logic [3:0] side_status;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_rx_demux #(.DW(32), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .loopback(loopback),
    .in_valid(in_valid), .in_is_ctrl(in_is_ctrl), .in_word(in_word),
    .hi_mark(hi_mark), .lo_mark(lo_mark), .rd_en(rd_en), .ovf_clr(ovf_clr),
    .rd_data(rd_data), .rd_sync(rd_sync), .empty(empty), .level(level),
    .suspend(suspend), .overflow(overflow), .side_status(side_status)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input bit ctrl, input logic [31:0] w);
    in_valid = 1'b1; in_is_ctrl = ctrl; in_word = w;
    @(negedge clk);
    in_valid = 1'b0; in_is_ctrl = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [31:0] w, input bit s);
    check(rd_data == w, req, 64'(rd_data), 64'(w));
    check(rd_sync == s, req, 64'(rd_sync), 64'(s));
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    check(empty == 1'b1, "R1 empty", 64'(empty), 1);
    check(level == 0, "R1 level", 64'(level), 0);
    check(suspend == 1'b0, "R1 suspend", 64'(suspend), 0);
    check(overflow == 1'b0, "R1 overflow", 64'(overflow), 0);
    check(side_status == 4'h0, "R1 side", 64'(side_status), 0);
  endtask

  task automatic t_order;
    send(0, 32'hA0A0_0001);
    check(level == 1 && !empty, "R2 level after one push", 64'(level), 1);
    send(0, 32'hA0A0_0002);
    send(0, 32'hA0A0_0003);
    check(level == 3, "R2 level", 64'(level), 3);
    pop_expect("R2 order first", 32'hA0A0_0001, 0);
    pop_expect("R2 order second", 32'hA0A0_0002, 0);
    pop_expect("R2 order third", 32'hA0A0_0003, 0);
    check(empty == 1'b1, "R2 drained", 64'(empty), 1);
  endtask

  task automatic t_ctrl_sync;
    // bits [4:0] = pio2=1 pio1=0 sync=1 dir=1 nrdy=0 -> side = 4'b1010
    send(1, 32'hFFFF_FF16);
    check(side_status == 4'b1010, "R3 side latch", 64'(side_status), 64'hA);
    check(level == 0, "R3 ctrl not stored", 64'(level), 0);
    send(0, 32'h0000_5A5A);
    send(0, 32'h0000_5A5B);
    pop_expect("R4 synced word", 32'h0000_5A5A, 1);
    pop_expect("R4 following word", 32'h0000_5A5B, 0);
    // pio2=0 pio1=1 sync=0 dir=0 nrdy=1 -> side = 4'b0101
    send(1, 32'h0000_0009);
    check(side_status == 4'b0101, "R3 side second", 64'(side_status), 64'h5);
    send(0, 32'h0000_0077);
    pop_expect("R4 no sync", 32'h0000_0077, 0);
  endtask

  task automatic t_ignore;
    rx_enable = 1'b0;
    send(0, 32'h1111_1111);
    send(1, 32'h0000_001F);
    check(level == 0, "R9 disabled data", 64'(level), 0);
    check(side_status == 4'b0101, "R9 disabled ctrl", 64'(side_status), 64'h5);
    rx_enable = 1'b1; loopback = 1'b1;
    send(0, 32'h2222_2222);
    send(1, 32'h0000_001A);
    check(level == 0, "R9 loopback data", 64'(level), 0);
    check(side_status == 4'b0101, "R9 loopback ctrl", 64'(side_status), 64'h5);
    loopback = 1'b0;
  endtask

  task automatic t_fill;
    for (int i = 0; i < 11; i++) send(0, 32'hC000_0000 + 32'(i));
    @(negedge clk);
    check(suspend == 1'b0, "R7 below high mark", 64'(suspend), 0);
    send(0, 32'hC000_000B);
    check(suspend == 1'b0, "R7 not yet", 64'(suspend), 0);
    @(negedge clk);
    check(suspend == 1'b1, "R7 at high mark", 64'(suspend), 1);
    for (int i = 12; i < 16; i++) send(0, 32'hC000_0000 + 32'(i));
    check(level == 16 && overflow == 1'b0, "R5 full no ovf", 64'(level), 16);
    send(0, 32'hDEAD_BEEF);
    check(overflow == 1'b1, "R5 overflow set", 64'(overflow), 1);
    check(level == 16, "R5 level kept", 64'(level), 16);
    @(negedge clk);
    check(overflow == 1'b1, "R6 sticky", 64'(overflow), 1);
    for (int i = 0; i < 12; i++) pop_expect("R5 contents", 32'hC000_0000 + 32'(i), 0);
    @(negedge clk);
    check(level == 4 && suspend == 1'b1, "R8 hold at low mark", 64'(suspend), 1);
    pop_expect("R5 contents", 32'hC000_000C, 0);
    check(suspend == 1'b1, "R8 not yet", 64'(suspend), 1);
    @(negedge clk);
    check(suspend == 1'b0, "R8 below low mark", 64'(suspend), 0);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check(overflow == 1'b0, "R6 cleared", 64'(overflow), 0);
    for (int i = 13; i < 16; i++) pop_expect("R5 contents tail", 32'hC000_0000 + 32'(i), 0);
    check(empty == 1'b1, "R5 no dropped word stored", 64'(empty), 1);
  endtask

  task automatic t_empty_pop;
    rd_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    check(level == 0 && empty, "R10 pop on empty", 64'(level), 0);
    send(0, 32'h0BAD_F00D);
    check(level == 1, "R10 level after push", 64'(level), 1);
    pop_expect("R10 word intact", 32'h0BAD_F00D, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_ctrl_sync();
    t_ignore();
    t_fill();
    t_empty_pop();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule